// File: doc/BRIEF.md
# Chainable 16-Tap Correlation Section

This block is one stage of a long cross-correlator or FIR filter. It keeps a 16-word delay line of signed 16-bit samples and a writable store of 16 signed 16-bit coefficients. Each accepted start strobe does two things. It pushes one new sample into the delay line. It then starts a serial multiply-accumulate over all 16 taps, which ends in a 40-bit signed result held on the output.

Several sections form a longer correlator: the oldest-sample output of one section drives the sample input of the next, and all sections share one start strobe. With four sections this gives a 64-point correlation. A separate adder, outside this block, sums the section results. Since unity-gain coefficient sets sum to 32768, that consumer scales the result down by 15 bits.

The coefficients are loaded before operation through a small write port. The port takes the initializer's 4-bit address unchanged and bit-inverts it internally. The word stored for initializer address k therefore always weights the sample accepted k strobes before the newest one. The accumulator walks the taps from the highest store address down to zero. A first section fed by a 12-bit unsigned converter gets its sample zero-extended to 16 bits by the instantiating logic.

Top module: `conv_section`

## Requirements
- R1: After reset, result_o and shift_o are zero, and every delay-line word and coefficient word is zero.
- R2: Each accepted strobe produces result_o = sum over k=0..15 of c[k]*x[k] as a 40-bit two's complement value. Here c[k] is the coefficient written at initializer address k and x[k] is the sample accepted k strobes before the latest one (x[0] is the latest). Samples older than reset count as zero, and samples and coefficients are both signed.
- R3: result_o changes only on the cycle a computation completes, and otherwise holds its value indefinitely.
- R4: A start strobe while en_i is low is ignored: no sample enters, shift_o and result_o are unchanged.
- R5: A write at initializer address a lands in store word ~a (4-bit inverse), so the word written at address k weights sample x[k]. An impulse fed into the section reads the coefficients back in address order 0..15.
- R6: A coefficient write takes effect only on a rising clock edge with coef_we_i high. Address and data driven while coef_we_i is low change nothing.
- R7: After an accepted strobe, shift_o holds x[15], the oldest sample in the delay line. Feeding shift_o into a second section on the same strobes makes the pair compute a contiguous 32-tap correlation.
- R8: The new result appears exactly 16 clock cycles after the edge that accepts the strobe. Before that, result_o still shows the previous value.
- R9: A start strobe arriving while a computation is in progress is ignored.
- R10: Full-scale inputs do not overflow. Sixteen products of -32768 by -32768 give +2^34, and 16 products of 32767 by -32768 give -17179344896.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Configuration complete; strobes are accepted only while high |
| start_i | input | 1 | Sample strobe, one cycle wide |
| sample_i | input | 16 | Signed sample in (previous section's shift_o in a chain) |
| shift_o | output | 16 | Oldest sample in the delay line, for the next section |
| coef_waddr_i | input | 4 | Initializer coefficient address (inverted inside) |
| coef_wdata_i | input | 16 | Signed coefficient write data |
| coef_we_i | input | 1 | Coefficient write enable for this section |
| result_o | output | 40 | Latched signed multiply-accumulate result |

## Verification
The bench runs an impulse through the section and checks that the coefficients come back in initializer address order. A design that dropped or doubled the address inversion would show them reversed. Random signed streams run through two chained sections. A one-strobe slip in the handoff between them would break the 32-tap sum of the second section, and an unsigned multiply would break the sum of the first. Further directed cases target three more faults:
- A design that counts the MAC window wrong would expose the new result a cycle early or late.
- A design that accepts strobes while disabled or busy would visibly advance shift_o.
- A design with a narrow accumulator would wrap the full-scale sums.

// File: rtl/conv_sec_pkg.sv
package conv_sec_pkg;
  localparam int TAPS_D   = 16;
  localparam int DATA_W_D = 16;
  localparam int COEF_W_D = 16;
  localparam int ACC_W_D  = 40;
endpackage

// File: rtl/conv_coef_store.sv
module conv_coef_store #(
  parameter int TAPS   = conv_sec_pkg::TAPS_D,
  parameter int COEF_W = conv_sec_pkg::COEF_W_D,
  localparam int AW    = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [COEF_W-1:0] rd_data_o
);
  logic [COEF_W-1:0] mem_q [TAPS];
  logic [AW-1:0]     waddr_inv;

  // data meets the highest address first, so store in reversed order
  assign waddr_inv = ~waddr_i;

  for (genvar g = 0; g < TAPS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && (waddr_inv == AW'(g)))      mem_q[g] <= wdata_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/conv_delay_line.sv
module conv_delay_line #(
  parameter int TAPS   = conv_sec_pkg::TAPS_D,
  parameter int DATA_W = conv_sec_pkg::DATA_W_D,
  localparam int AW    = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] oldest_o
);
  // slot 0 oldest, slot TAPS-1 newest
  logic [DATA_W-1:0] dl_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    if (g == TAPS - 1) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    dl_q[g] <= '0;
        else if (adv_i) dl_q[g] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    dl_q[g] <= '0;
        else if (adv_i) dl_q[g] <= dl_q[g+1];
      end
    end
  end

  assign rd_data_o = dl_q[rd_idx_i];
  assign oldest_o  = dl_q[0];
endmodule

// File: rtl/conv_mac_seq.sv
module conv_mac_seq #(
  parameter int TAPS  = conv_sec_pkg::TAPS_D,
  parameter int PW    = 32,
  parameter int ACC_W = conv_sec_pkg::ACC_W_D,
  localparam int AW   = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [PW-1:0]    prod_i,
  output logic [AW-1:0]    idx_o,
  output logic             busy_o,
  output logic [ACC_W-1:0] result_o
);
  logic [AW-1:0]    idx_q;
  logic             busy_q;
  logic [ACC_W-1:0] acc_q, result_q, prod_ext, acc_nx;

  assign prod_ext = {{(ACC_W-PW){prod_i[PW-1]}}, prod_i};
  assign acc_nx   = acc_q + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      busy_q   <= 1'b0;
      acc_q    <= '0;
      result_q <= '0;
    end else if (go_i) begin
      idx_q  <= AW'(TAPS - 1);
      busy_q <= 1'b1;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_nx;
      idx_q <= idx_q - 1'b1;
      if (idx_q == '0) begin
        busy_q   <= 1'b0;
        result_q <= acc_nx;
      end
    end
  end

  assign idx_o    = idx_q;
  assign busy_o   = busy_q;
  assign result_o = result_q;
endmodule

// File: rtl/conv_section.sv
module conv_section #(
  parameter int TAPS   = conv_sec_pkg::TAPS_D,
  parameter int DATA_W = conv_sec_pkg::DATA_W_D,
  parameter int COEF_W = conv_sec_pkg::COEF_W_D,
  parameter int ACC_W  = conv_sec_pkg::ACC_W_D,
  localparam int AW    = $clog2(TAPS),
  localparam int PW    = DATA_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] shift_o,
  input  logic [AW-1:0]     coef_waddr_i,
  input  logic [COEF_W-1:0] coef_wdata_i,
  input  logic              coef_we_i,
  output logic [ACC_W-1:0]  result_o
);
  logic              busy_w, go_w;
  logic [AW-1:0]     idx_w;
  logic [DATA_W-1:0] tap_w;
  logic [COEF_W-1:0] coef_w;
  logic [PW-1:0]     prod_w;

  assign go_w   = start_i & en_i & ~busy_w;
  assign prod_w = PW'($signed(tap_w) * $signed(coef_w));

  conv_coef_store #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i, .rst_ni,
    .we_i      (coef_we_i),
    .waddr_i   (coef_waddr_i),
    .wdata_i   (coef_wdata_i),
    .rd_idx_i  (idx_w),
    .rd_data_o (coef_w)
  );

  conv_delay_line #(.TAPS(TAPS), .DATA_W(DATA_W)) u_dl (
    .clk_i, .rst_ni,
    .adv_i     (go_w),
    .din_i     (sample_i),
    .rd_idx_i  (idx_w),
    .rd_data_o (tap_w),
    .oldest_o  (shift_o)
  );

  conv_mac_seq #(.TAPS(TAPS), .PW(PW), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni,
    .go_i     (go_w),
    .prod_i   (prod_w),
    .idx_o    (idx_w),
    .busy_o   (busy_w),
    .result_o (result_o)
  );
endmodule

// File: rtl/conv_section_chk.sv
module conv_section_chk #(
  parameter int TAPS   = conv_sec_pkg::TAPS_D,
  parameter int DATA_W = conv_sec_pkg::DATA_W_D,
  parameter int ACC_W  = conv_sec_pkg::ACC_W_D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              start_i,
  input logic [DATA_W-1:0] shift_o,
  input logic [ACC_W-1:0]  result_o,
  input logic              busy_w
);
  logic [7:0] run_cnt;
  logic       accept;

  assign accept = start_i && en_i && !busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (accept) run_cnt <= '0;
    else if (busy_w) run_cnt <= run_cnt + 1'b1;
  end

  assert_hold_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $fell(busy_w));

  assert_disabled_no_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_w) |=> $stable(shift_o) && $stable(result_o));

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_w);

  assert_window_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_w) |-> (run_cnt == 8'(TAPS)));

  assert_busy_ignores_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |=> $stable(shift_o));
endmodule

bind conv_section conv_section_chk #(.TAPS(TAPS), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .start_i, .shift_o, .result_o, .busy_w
);

// File: tb/tb_conv_section.sv
module tb_conv_section;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b0, start = 1'b0;
  logic [15:0] sample = '0;
  logic [3:0]  waddr = '0;
  logic [15:0] wdata = '0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [15:0] shift_a, shift_b;
  logic [39:0] res_a, res_b;

  int checks = 0, errors = 0;
  longint c_a [16], c_b [16], hist [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_section dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .sample_i(sample),
    .shift_o(shift_a), .coef_waddr_i(waddr), .coef_wdata_i(wdata), .coef_we_i(we_a),
    .result_o(res_a));

  conv_section dut_nx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .sample_i(shift_a),
    .shift_o(shift_b), .coef_waddr_i(waddr), .coef_wdata_i(wdata), .coef_we_i(we_b),
    .result_o(res_b));

  function automatic longint exp_a();
    longint s = 0;
    for (int k = 0; k < 16; k++) s += c_a[k] * hist[k];
    return s;
  endfunction

  function automatic longint exp_b();
    longint s = 0;
    for (int k = 0; k < 16; k++) s += c_b[k] * hist[16+k];
    return s;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint s40(logic [39:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint s16(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic wr(int sec, int a, longint d, bit we);
    @(negedge clk);
    waddr = 4'(a); wdata = 16'(d);
    we_a = we && (sec == 0); we_b = we && (sec == 1);
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
    if (we && sec == 0) c_a[a] = d;
    if (we && sec == 1) c_b[a] = d;
  endtask

  // accepted strobe; waits until the result is due
  task automatic push(logic [15:0] x);
    @(negedge clk);
    sample = x; start = 1'b1; en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s16(x);
    repeat (16) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint old_r, sh_old;
    int seed;
    seed = $urandom(32'd7);
    for (int i = 0; i < 16; i++) begin c_a[i] = 0; c_b[i] = 0; end
    for (int i = 0; i < 32; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result", s40(res_a), 0);
    chk("R1 shift", s16(shift_a), 0);

    // R5: coefficient per address, then R6: writes with enable low
    for (int k = 0; k < 16; k++) wr(0, k, k * 100 + 1 - (k % 3) * 2000, 1'b1);
    for (int k = 0; k < 16; k++) wr(0, k, 16'h7abc, 1'b0);
    push(16'd1);
    chk("R5 impulse tap 0", s40(res_a), c_a[0]);
    for (int k = 1; k < 16; k++) begin
      push(16'd0);
      chk($sformatf("R5 R6 impulse tap %0d", k), s40(res_a), c_a[k]);
    end

    // R2, R7: random signed streams through two chained sections
    for (int k = 0; k < 16; k++) wr(0, k, longint'($signed(16'($urandom))), 1'b1);
    for (int k = 0; k < 16; k++) wr(1, k, longint'($signed(16'($urandom))), 1'b1);
    for (int n = 0; n < 60; n++) begin
      push(16'($urandom));
      chk("R2 random sum", s40(res_a), exp_a());
      chk("R7 chained sum", s40(res_b), exp_b());
      chk("R7 shift out", s16(shift_a), hist[15]);
    end

    // R8: exact latency
    old_r = s40(res_a);
    @(negedge clk);
    sample = 16'h4321; start = 1'b1; en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s16(16'h4321);
    repeat (15) @(negedge clk);
    chk("R8 before window end", s40(res_a), old_r);
    @(negedge clk);
    chk("R8 at window end", s40(res_a), exp_a());

    // R3: hold while idle
    old_r = s40(res_a);
    repeat (40) @(negedge clk);
    chk("R3 hold", s40(res_a), old_r);

    // R4: strobe while disabled
    sh_old = s16(shift_a);
    @(negedge clk);
    en = 1'b0; sample = 16'h1111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 shift unchanged", s16(shift_a), sh_old);
    chk("R4 result unchanged", s40(res_a), old_r);
    en = 1'b1;

    // R9: second strobe during computation
    @(negedge clk);
    sample = 16'h0ff0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s16(16'h0ff0);
    repeat (4) @(negedge clk);
    sample = 16'h8001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 busy strobe result", s40(res_a), exp_a());
    chk("R9 busy strobe shift", s16(shift_a), hist[15]);

    // R10: full scale
    for (int k = 0; k < 16; k++) wr(0, k, -32768, 1'b1);
    for (int k = 0; k < 16; k++) push(16'h8000);
    chk("R10 max positive", s40(res_a), 64'sd17179869184);
    for (int k = 0; k < 16; k++) wr(0, k, 32767, 1'b1);
    push(16'h8000);
    chk("R10 max negative", s40(res_a), -64'sd17179344896);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule